// File: doc/BRIEF.md
# Gated Three-Tone Sine Tune Generator

This block turns a level-sensitive play request into a repeating three-note melody. It reads a stored single-cycle sine table and sends 8-bit unsigned samples to an external resistor-ladder DAC. The table is stepped one entry at a time. A reload counter sets how many clock cycles each entry is held, and that hold time sets the pitch. A free-running elapsed-time counter retunes the same stepping engine once per second. The result is a low note, then a middle note, then a high note, after which the melody starts again.

The play request may arrive from any clock domain. A two-flop synchroniser brings it into the clock domain before use. While the request is low, playback freezes and the elapsed time is cleared, so every new request starts on the first note. The sample output drives a DAC as a continuous level. It has no valid/ready handshake and no back-pressure: the DAC takes whatever value is present on every cycle.

Top module: `tone_tune_gen`

## Requirements
- R1: A synchronous reset sets `sample` to midscale 128 and clears all state. If `play_en` is first seen high at rising edge k, `sample` still shows entry 0 after edge k+2 and shows entry 1 after edge k+3.
- R2: Table entry a, for 0 <= a < N where N = TABLE_LEN (default 629), equals round(128 + 127·sin(2π·a/N)) as an unsigned 8-bit value. Entry 0 is therefore 128.
- R3: The table address advances by exactly one per step. After entry N-1 the next entry is 0.
- R4: While note n plays, each entry is held for D_n = CLK_HZ / (f_n · N) clock cycles, using integer division. With the defaults of 25 MHz and 200/440/700 Hz, the hold times are 198, 90 and 56 cycles.
- R5: Measured in enabled cycles from the start of the tune, note 0 plays for the first CLK_HZ cycles, note 1 for the next CLK_HZ cycles and note 2 for the CLK_HZ cycles after that. The tune then repeats from note 0 every 3·CLK_HZ cycles. The elapsed-time counter is TIME_W bits wide (default 27).
- R6: A new hold time takes effect at the next reload. The address is not reset at a note change, so each sample stays the table successor of the one before it.
- R7: While `play_en` is low, `sample` stays constant from the third rising edge after the low level is first seen. Neither the address nor the hold counter advances.
- R8: A low level on `play_en` clears elapsed time, so every re-enable starts on note 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| play_en | input | 1 | Asynchronous play request level |
| sample | output | SAMPLE_W | Unsigned sample to the DAC |

## Verification
The bench runs the block scaled down to a 16-entry table and a short "second". It first drives a fresh enable after reset and checks every step through a full table wrap, including the cycle just before each step. This separates a wrong table value from a hold time that is off by one. Hold lengths are then measured deep inside each of the three note windows and again after the tune repeats, which tells apart a wrong divider from a wrong schedule. Transitions across two note boundaries are checked for table continuity, which exposes an address reset. Finally, a mid-tune disable, a re-enable and a reset during play show the freeze and prove that every restart lands on the first note.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    NOTE_LOW  = 2'd0,
    NOTE_MID  = 2'd1,
    NOTE_HIGH = 2'd2
  } note_e;

  localparam real TWO_PI = 6.283185307179586;

  // Elaboration-time sine sample: round(mid + (mid-1)*sin(2*pi*idx/len)).
  function automatic int sine_entry(int idx, int len, int width);
    real x;
    real term;
    real acc;
    int  mid;
    x = TWO_PI * real'(idx) / real'(len);
    if (x > TWO_PI / 2.0) x = x - TWO_PI;
    term = x;
    acc  = x;
    for (int n = 1; n < 10; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    mid = 1 << (width - 1);
    return $rtoi(real'(mid) + real'(mid - 1) * acc + 0.5);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tone_sequencer.sv
module tone_sequencer
  import tone_pkg::*;
#(
  parameter int CLK_HZ = 25_000_000,
  parameter int TIME_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output note_e             note,
  output logic [TIME_W-1:0] elapsed
);
  localparam logic [TIME_W-1:0] END_LOW  = TIME_W'(CLK_HZ - 1);
  localparam logic [TIME_W-1:0] END_MID  = TIME_W'(2 * CLK_HZ - 1);
  localparam logic [TIME_W-1:0] END_TUNE = TIME_W'(3 * CLK_HZ - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      elapsed <= '0;
      note    <= NOTE_LOW;
    end else if (elapsed == END_TUNE) begin
      elapsed <= '0;
      note    <= NOTE_LOW;
    end else begin
      elapsed <= elapsed + 1'b1;
      if (elapsed == END_LOW)      note <= NOTE_MID;
      else if (elapsed == END_MID) note <= NOTE_HIGH;
    end
  end
endmodule

// File: rtl/tone_stepper.sv
module tone_stepper #(
  parameter int TABLE_LEN = 629,
  parameter int CNT_W     = 8,
  localparam int ADDR_W   = $clog2(TABLE_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CNT_W-1:0]  hold,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TABLE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      addr  <= '0;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q <= hold - 1'b1;
        if (addr == LAST_ADDR) addr <= '0;
        else                   addr <= addr + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int TABLE_LEN = 629,
  parameter int WIDTH     = 8,
  localparam int ADDR_W   = $clog2(TABLE_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [WIDTH-1:0]  q
);
  localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] entries [TABLE_LEN];

  for (genvar gi = 0; gi < TABLE_LEN; gi++) begin : g_entry
    localparam logic [WIDTH-1:0] VAL = WIDTH'(tone_pkg::sine_entry(gi, TABLE_LEN, WIDTH));
    assign entries[gi] = VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= MID;
    else     q <= entries[addr];
  end
endmodule

// File: rtl/tone_tune_gen.sv
module tone_tune_gen
  import tone_pkg::*;
#(
  parameter int CLK_HZ    = 25_000_000,
  parameter int TABLE_LEN = 629,
  parameter int SAMPLE_W  = 8,
  parameter int NOTE0_HZ  = 200,
  parameter int NOTE1_HZ  = 440,
  parameter int NOTE2_HZ  = 700,
  parameter int TIME_W    = 27
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                play_en,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int HOLD0    = CLK_HZ / NOTE0_HZ / TABLE_LEN;
  localparam int HOLD1    = CLK_HZ / NOTE1_HZ / TABLE_LEN;
  localparam int HOLD2    = CLK_HZ / NOTE2_HZ / TABLE_LEN;
  localparam int HOLD_MAX = max3(HOLD0, HOLD1, HOLD2);
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);
  localparam int ADDR_W   = $clog2(TABLE_LEN);

  logic              en_sync;
  note_e             note;
  logic [TIME_W-1:0] elapsed;
  logic [CNT_W-1:0]  hold;
  logic [ADDR_W-1:0] rd_addr;

  tone_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (play_en),
    .dout(en_sync)
  );

  tone_sequencer #(.CLK_HZ(CLK_HZ), .TIME_W(TIME_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .run    (en_sync),
    .note   (note),
    .elapsed(elapsed)
  );

  always_comb begin
    case (note)
      NOTE_LOW: hold = CNT_W'(HOLD0);
      NOTE_MID: hold = CNT_W'(HOLD1);
      default:  hold = CNT_W'(HOLD2);
    endcase
  end

  tone_stepper #(.TABLE_LEN(TABLE_LEN), .CNT_W(CNT_W)) u_step (
    .clk (clk),
    .rst (rst),
    .run (en_sync),
    .hold(hold),
    .addr(rd_addr)
  );

  tone_sine_rom #(.TABLE_LEN(TABLE_LEN), .WIDTH(SAMPLE_W)) u_rom (
    .clk (clk),
    .rst (rst),
    .addr(rd_addr),
    .q   (sample)
  );
endmodule

// File: rtl/tone_tune_gen_chk.sv
module tone_tune_gen_chk
  import tone_pkg::*;
#(
  parameter int CLK_HZ    = 25_000_000,
  parameter int TABLE_LEN = 629,
  parameter int SAMPLE_W  = 8,
  parameter int TIME_W    = 27,
  localparam int ADDR_W   = $clog2(TABLE_LEN)
) (
  input logic                clk,
  input logic                rst,
  input logic                en_sync,
  input note_e               note,
  input logic [TIME_W-1:0]   elapsed,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [SAMPLE_W-1:0] sample
);
  localparam logic [SAMPLE_W-1:0] MID      = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0]   LAST_A   = ADDR_W'(TABLE_LEN - 1);
  localparam logic [TIME_W-1:0]   SEC      = TIME_W'(CLK_HZ);
  localparam logic [TIME_W-1:0]   END_TUNE = TIME_W'(3 * CLK_HZ - 1);

  p_reset_mid_r1: assert property (@(posedge clk) rst |=> sample == MID);

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    rd_addr <= LAST_A);

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (rst)
    rd_addr != $past(rd_addr) |->
      rd_addr == (($past(rd_addr) == LAST_A) ? '0 : $past(rd_addr) + 1'b1));

  p_first_note_r5: assert property (@(posedge clk) disable iff (rst)
    elapsed < SEC |-> note == NOTE_LOW);

  p_time_bound_r5: assert property (@(posedge clk) disable iff (rst)
    elapsed <= END_TUNE);

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    !en_sync |=> $stable(rd_addr));

  p_time_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !en_sync |=> elapsed == '0);
endmodule

bind tone_tune_gen tone_tune_gen_chk #(
  .CLK_HZ(CLK_HZ), .TABLE_LEN(TABLE_LEN), .SAMPLE_W(SAMPLE_W), .TIME_W(TIME_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en_sync(en_sync),
  .note   (note),
  .elapsed(elapsed),
  .rd_addr(rd_addr),
  .sample (sample)
);

// File: tb/tone_tune_gen_tb.sv
module tone_tune_gen_tb;
  localparam int CLK_HZ = 960;
  localparam int N      = 16;
  localparam int F0     = 12;
  localparam int F1     = 20;
  localparam int F2     = 30;
  localparam int D0     = CLK_HZ / F0 / N;
  localparam int D1     = CLK_HZ / F1 / N;
  localparam int D2     = CLK_HZ / F2 / N;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       play_en = 1'b0;
  logic [7:0] sample;
  int         cyc = 0;
  int         total = 0;
  int         bad = 0;
  int         e1 = 0;

  tone_tune_gen #(
    .CLK_HZ(CLK_HZ), .TABLE_LEN(N), .SAMPLE_W(8),
    .NOTE0_HZ(F0), .NOTE1_HZ(F1), .NOTE2_HZ(F2), .TIME_W(27)
  ) u_dut (
    .clk    (clk),
    .rst    (rst),
    .play_en(play_en),
    .sample (sample)
  );

  initial forever #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_entry(int a);
    return $rtoi(128.0 + 127.0 * $sin(6.283185307179586 * real'(a % N) / real'(N)) + 0.5);
  endfunction

  function automatic int is_succ(int prev, int nxt);
    for (int i = 0; i < N; i++)
      if (ref_entry(i) == prev && ref_entry((i + 1) % N) == nxt) return 1;
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_change(output int n);
    int prev;
    prev = sample;
    n = 0;
    do begin
      tick(1);
      n++;
    end while (sample == prev && n < 400);
  endtask

  task automatic measure_gap(string req, int exp);
    int n;
    wait_change(n);
    wait_change(n);
    check(req, "entry hold length", n, exp);
  endtask

  task automatic track_successors(string req, int count);
    int prev;
    int n;
    for (int k = 0; k < count; k++) begin
      prev = sample;
      wait_change(n);
      check(req, "table successor", is_succ(prev, sample), 1);
    end
  endtask

  // R1, R7: reset value and idle hold
  task automatic t_reset_idle();
    tick(5);
    check("R1", "sample in reset", sample, 128);
    rst = 1'b0;
    tick(40);
    check("R7", "idle sample", sample, 128);
  endtask

  // R1, R2, R3, R4: start latency, table values, wrap, note-0 hold
  task automatic t_start_sweep();
    play_en = 1'b1;
    tick(3);
    check("R1", "entry 0 before first step", sample, ref_entry(0));
    tick(1);
    check("R1", "first step latency", sample, ref_entry(1));
    e1 = cyc - 1;
    for (int k = 2; k <= N + 1; k++) begin
      tick(D0 - 1);
      check("R4", "held entry", sample, ref_entry(k - 1));
      tick(1);
      check((k == N) ? "R3" : "R2", "table entry", sample, ref_entry(k));
    end
  endtask

  // R5, R6: schedule, repeat, phase continuity over boundaries
  task automatic t_schedule();
    wait_until(e1 + CLK_HZ + 200);
    measure_gap("R5", D1);
    wait_until(e1 + 2 * CLK_HZ + 200);
    measure_gap("R5", D2);
    wait_until(e1 + 3 * CLK_HZ + 200);
    measure_gap("R5", D0);
    wait_until(e1 + 4 * CLK_HZ - 25);
    track_successors("R6", 24);
    wait_until(e1 + 5 * CLK_HZ - 20);
    track_successors("R6", 24);
  endtask

  // R7, R8: freeze while low, restart on first note
  task automatic t_pause_restart();
    int held;
    int changed;
    wait_until(e1 + 5 * CLK_HZ + 200);
    play_en = 1'b0;
    tick(3);
    held = sample;
    changed = 0;
    for (int k = 0; k < 100; k++) begin
      tick(1);
      if (sample != held) changed = 1;
    end
    check("R7", "output changed while disabled", changed, 0);
    play_en = 1'b1;
    measure_gap("R8", D0);
  endtask

  // R1, R8: reset during play, then restart
  task automatic t_reset_in_play();
    tick(D0 * 2 + 1);
    rst = 1'b1;
    tick(1);
    check("R1", "sample after reset edge", sample, 128);
    tick(3);
    rst = 1'b0;
    tick(3);
    check("R1", "entry 0 after reset release", sample, ref_entry(0));
    tick(1);
    check("R1", "first step after reset release", sample, ref_entry(1));
    measure_gap("R8", D0);
  endtask

  initial begin
    t_reset_idle();
    t_start_sweep();
    t_schedule();
    t_pause_restart();
    t_reset_in_play();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule